// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block gathers up to six internal interrupt sources and one request arriving from the external inter-module bus. It raises a single interrupt request toward the processor. When the processor later runs its interrupt-acknowledge read, the block supplies a restart-style vector byte for the highest-priority pending internal source.

The acknowledge read is recognised when the processor's data-bus-in strobe and its interrupt-acknowledge status are both high. At that moment the block freezes the winning source, so the vector stays fixed for the rest of the read. If the winner is internal, the block drives the vector and pulses a flag. The status register latches that flag to release the processor from its wait state. If only the external request is pending, the block leaves the data bus undriven. It then raises an acknowledge on the inter-module bus, and the interrupting module supplies the response.

All request inputs are asynchronous and are synchronised inside the block. All outputs are registered.

Top module: `irq_vector_unit`

## Requirements
- R1: While `rst` is sampled high, and on the edge after it, `int_req`, `data_oe`, `int_flag`, `bus_ack` and `data_out` are all zero.
- R2: `int_req` is registered. Its value is the OR of every unmasked internal request and the external request (active when `ext_req_n` is low), each taken through a two-flop synchroniser. A change at the inputs therefore reaches `int_req` on the third rising edge.
- R3: An internal source whose `src_mask` bit is 1 is ignored. It neither raises `int_req` nor wins the vector selection.
- R4: The acknowledge window is open only while `dbin` and `inta` are both 1. With either one low, `data_oe`, `int_flag` and `bus_ack` are 0 from the next edge on.
- R5: Among pending unmasked internal sources, bit 0 of `src_req` has priority 1 (highest) and bit 5 has priority 6 (lowest). The lowest-numbered pending bit wins.
- R6: From the first edge at which the window is open, and for as long as it stays open, `data_out` carries 8'b11_nnn_111 with `data_oe` = 1. Here nnn is the winner's priority number, its bit index plus one.
- R7: The winner and its vector are captured on the edge at which the window opens. Requests that change while the window stays open do not alter `data_out`.
- R8: `int_flag` is high for exactly one cycle, on the edge that opens the window, and only when an internal winner was captured.
- R9: If no unmasked internal request is pending when the window opens, `data_oe` stays 0 for the whole window.
- R10: `bus_ack` is high while the window is open if, at its opening, the external request was active and no internal winner was captured. It falls on the edge after the window closes.
- R11: `data_out` is 8'h00 whenever `data_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 6 | Internal interrupt requests, bit 0 highest priority |
| src_mask | input | 6 | Per-source mask, 1 blocks the source |
| ext_req_n | input | 1 | External-bus interrupt request, active low |
| dbin | input | 1 | Processor data-bus-in strobe |
| inta | input | 1 | Interrupt-acknowledge status from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| data_out | output | 8 | Vector byte |
| data_oe | output | 1 | Data bus drive enable for `data_out` |
| int_flag | output | 1 | Internal-interrupt pulse for the status register |
| bus_ack | output | 1 | Acknowledge onto the inter-module bus |

## Verification
The bench tries several request patterns. A single low-priority source checks the vector encoding without any priority effect. A mixed set of sources separates the correct winner from neighbouring bits. A high-priority request arriving while the window is open distinguishes a captured winner from a live one. A masked high-priority source shows whether masking reaches both the request and the selection. Two further patterns cover the data-path and bus-acknowledge split: an external-only request, and an external request alongside an internal one. Strobe-only and status-only cycles confirm that half a window produces no output.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int unsigned MAX_SRC = 7;

  typedef struct packed {
    logic       valid;
    logic [2:0] code;
    logic       ext;
  } irqv_win_t;

  function automatic logic [7:0] restart_byte(input logic [2:0] code);
    return {2'b11, code, 3'b111};
  endfunction
endpackage

// File: rtl/irqv_sync.sv
module irqv_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= RST_VAL;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= RST_VAL;
      else     chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irqv_prio.sv
module irqv_prio #(
  parameter int unsigned NUM_SRC = 6,
  localparam int unsigned CW = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               any,
  output logic [CW-1:0]      code
);
  logic [NUM_SRC:0]   seen;
  logic [NUM_SRC-1:0] first;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign seen[i+1] = seen[i] | pend[i];
    assign first[i]  = pend[i] & ~seen[i];
  end

  always_comb begin
    code = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (first[i]) code = code | CW'(i + 1);
    end
  end

  assign any = seen[NUM_SRC];
endmodule

// File: rtl/irqv_ack_ctrl.sv
module irqv_ack_ctrl
  import irqv_pkg::*;
#(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_int,
  input  logic          pend_any,
  input  logic [CW-1:0] pend_code,
  input  logic          ext_act,
  output logic [7:0]    data_out,
  output logic          data_oe,
  output logic          int_flag,
  output logic          bus_ack
);
  logic      en_q;
  irqv_win_t win_q, win_d;
  logic      opening;

  assign opening = en_int & ~en_q;

  always_comb begin
    win_d = win_q;
    if (opening) begin
      win_d.valid = pend_any;
      win_d.code  = 3'(pend_code);
      win_d.ext   = ext_act;
    end else if (!en_int) begin
      win_d.valid = 1'b0;
      win_d.ext   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      win_q    <= '0;
      data_out <= '0;
      data_oe  <= 1'b0;
      int_flag <= 1'b0;
      bus_ack  <= 1'b0;
    end else begin
      en_q     <= en_int;
      win_q    <= win_d;
      data_oe  <= en_int & win_d.valid;
      data_out <= (en_int & win_d.valid) ? restart_byte(win_d.code) : 8'h00;
      int_flag <= opening & pend_any;
      bus_ack  <= en_int & ~win_d.valid & win_d.ext;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int unsigned NUM_SRC     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_req,
  input  logic [NUM_SRC-1:0] src_mask,
  input  logic               ext_req_n,
  input  logic               dbin,
  input  logic               inta,
  output logic               int_req,
  output logic [7:0]         data_out,
  output logic               data_oe,
  output logic               int_flag,
  output logic               bus_ack
);
  localparam int unsigned CW = $clog2(NUM_SRC + 1);

  logic [NUM_SRC-1:0] src_s;
  logic               ext_s_n;
  logic [NUM_SRC-1:0] pend;
  logic               pend_any;
  logic [CW-1:0]      pend_code;
  logic               en_int;

  irqv_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_src_sync (
    .clk(clk), .rst(rst), .d(src_req), .q(src_s)
  );

  irqv_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst(rst), .d(ext_req_n), .q(ext_s_n)
  );

  assign pend   = src_s & ~src_mask;
  assign en_int = dbin & inta;

  irqv_prio #(.NUM_SRC(NUM_SRC)) u_prio (
    .pend(pend), .any(pend_any), .code(pend_code)
  );

  always_ff @(posedge clk) begin
    if (rst) int_req <= 1'b0;
    else     int_req <= pend_any | ~ext_s_n;
  end

  irqv_ack_ctrl #(.CW(CW)) u_ack (
    .clk(clk), .rst(rst), .en_int(en_int),
    .pend_any(pend_any), .pend_code(pend_code), .ext_act(~ext_s_n),
    .data_out(data_out), .data_oe(data_oe),
    .int_flag(int_flag), .bus_ack(bus_ack)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker (
  input logic       clk,
  input logic       rst,
  input logic       dbin,
  input logic       inta,
  input logic [7:0] data_out,
  input logic       data_oe,
  input logic       int_flag,
  input logic       bus_ack
);
  p_closed_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !($past(dbin) && $past(inta)) |-> (!data_oe && !int_flag && !bus_ack));

  p_vector_shape_r6: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_out[7:6] == 2'b11 && data_out[2:0] == 3'b111 && data_out[5:3] != 3'b000));

  p_frozen_vector_r7: assert property (@(posedge clk) disable iff (rst)
    (data_oe && $past(data_oe)) |-> $stable(data_out));

  p_flag_single_r8: assert property (@(posedge clk) disable iff (rst)
    int_flag |=> !int_flag);

  p_flag_with_drive_r8: assert property (@(posedge clk) disable iff (rst)
    int_flag |-> data_oe);

  p_ack_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(bus_ack && data_oe));

  p_idle_bus_zero_r11: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == 8'h00));
endmodule

bind irq_vector_unit irqv_checker u_chk (
  .clk(clk), .rst(rst), .dbin(dbin), .inta(inta),
  .data_out(data_out), .data_oe(data_oe),
  .int_flag(int_flag), .bus_ack(bus_ack)
);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] src_req = '0;
  logic [5:0] src_mask = '0;
  logic       ext_req_n = 1'b1;
  logic       dbin = 1'b0;
  logic       inta = 1'b0;
  logic       int_req, data_oe, int_flag, bus_ack;
  logic [7:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  irq_vector_unit u0 (
    .clk(clk), .rst(rst), .src_req(src_req), .src_mask(src_mask),
    .ext_req_n(ext_req_n), .dbin(dbin), .inta(inta),
    .int_req(int_req), .data_out(data_out), .data_oe(data_oe),
    .int_flag(int_flag), .bus_ack(bus_ack)
  );

  // behavioural reference model
  logic [5:0] ms1, ms2;
  logic       me1, me2, m_req, m_enq, m_wv, m_we, m_oe, m_flag, m_ack;
  int         m_wc;
  logic [7:0] m_dout;

  always @(posedge clk) begin
    logic [5:0] pend;
    logic eact, en, rise;
    if (rst) begin
      ms1 = '0; ms2 = '0; me1 = 1; me2 = 1; m_req = 0; m_enq = 0;
      m_wv = 0; m_we = 0; m_wc = 0; m_oe = 0; m_flag = 0; m_ack = 0; m_dout = 0;
    end else begin
      pend = ms2 & ~src_mask;
      eact = !me2;
      en   = dbin && inta;
      rise = en && !m_enq;
      m_req = (pend != 0) || eact;
      if (rise) begin
        m_wv = (pend != 0);
        m_we = eact;
        m_wc = 0;
        for (int k = 5; k >= 0; k--) if (pend[k]) m_wc = k + 1;
      end else if (!en) begin
        m_wv = 0;
        m_we = 0;
      end
      m_oe   = en && m_wv;
      m_dout = m_oe ? {2'b11, 3'(m_wc), 3'b111} : 8'h00;
      m_flag = rise && m_wv;
      m_ack  = en && !m_wv && m_we;
      m_enq  = en;
      ms2 = ms1; ms1 = src_req;
      me2 = me1; me1 = ext_req_n;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R2 int_req", int_req, m_req);
      chk("R9 data_oe", data_oe, m_oe);
      chk("R6 data_out", data_out, m_dout);
      chk("R8 int_flag", int_flag, m_flag);
      chk("R10 bus_ack", bus_ack, m_ack);
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle_sample();
    @(negedge clk);
    #0.5;
  endtask

  task automatic close_window();
    dbin = 0; inta = 0; src_req = '0; src_mask = '0; ext_req_n = 1;
    step(5);
  endtask

  initial begin
    step(3);
    settle_sample();
    chk("R1 reset int_req", int_req, 0);
    chk("R1 reset data_oe", data_oe, 0);
    chk("R1 reset bus_ack", bus_ack, 0);
    chk("R1 reset data_out", data_out, 0);
    step(0); rst = 0;
    step(2);

    // single low-priority source
    src_req = 6'b100000; step(3);
    settle_sample(); chk("R2 request latency", int_req, 1);
    step(0); dbin = 1; step(2);
    settle_sample(); chk("R4 strobe only", data_oe, 0);
    step(0); inta = 1; step(1);
    settle_sample(); chk("R8 flag at open", int_flag, 1);
    chk("R6 vector code6", data_out, 8'hF7);
    step(0); inta = 0; step(1);
    settle_sample(); chk("R4 window closed", data_oe, 0);
    close_window();

    // mixed sources
    src_req = 6'b101100; step(4);
    dbin = 1; inta = 1; step(2);
    settle_sample(); chk("R5 winner bit2", data_out, 8'hDF);
    step(0); close_window();

    // late high-priority arrival
    src_req = 6'b010000; step(4);
    dbin = 1; inta = 1; step(1);
    src_req = 6'b010001; step(5);
    settle_sample(); chk("R7 frozen code5", data_out, 8'hEF);
    step(0); close_window();

    // masking
    src_req = 6'b001001; src_mask = 6'b000001; step(4);
    dbin = 1; inta = 1; step(2);
    settle_sample(); chk("R3 masked winner", data_out, 8'hE7);
    step(0); close_window();
    src_req = 6'b000100; src_mask = 6'b000100; step(4);
    settle_sample(); chk("R3 masked request", int_req, 0);
    step(0); close_window();

    // external only
    ext_req_n = 0; step(4);
    dbin = 1; inta = 1; step(2);
    settle_sample(); chk("R9 no drive", data_oe, 0);
    chk("R10 bus ack", bus_ack, 1);
    chk("R11 idle bus", data_out, 0);
    step(0); dbin = 0; step(1);
    settle_sample(); chk("R10 ack drop", bus_ack, 0);
    step(0); close_window();

    // external plus internal
    ext_req_n = 0; src_req = 6'b000010; step(4);
    dbin = 1; inta = 1; step(2);
    settle_sample(); chk("R10 internal wins", bus_ack, 0);
    chk("R6 vector code2", data_out, 8'hD7);
    step(0); close_window();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule